// File: doc/BRIEF.md
# Bus-Mastering Ones-Complement Checksum Engine

This block is a memory-mapped accelerator that adds up a packet payload as a stream of 16-bit words using ones-complement arithmetic, the sum used by internet transport protocols. Software programs a start address and a byte count through a small register window and then writes a start command. The engine then fetches the payload from shared data memory on its own read master, without the processor copying any data, and leaves the folded 16-bit sum in a readable result register.

The read master competes with the processor for the same SRAM, so any request may be held off by the arbiter for any number of cycles. The master keeps up to two reads in flight so that, with one cycle of read latency and no contention, it sustains one 32-bit word per clock. A 1300-byte payload therefore finishes in a little over 325 cycles. Software applies the final bit inversion itself; the engine reports the folded sum uninverted.

Top module: `csum_engine`

## Requirements
- R1: The register window uses byte offsets on `s_addr[3:2]`: 0x0 start address, 0x4 byte count, 0x8 control/status, 0xC result. Status reads return busy in bit 0 and done in bit 1; the result reads in bits 15:0 with bits 31:16 zero. After reset every register reads 0.
- R2: The result is the ones-complement sum of the payload taken as 16-bit words, with each carry out of bit 15 added back into bit 0 until none remains. The byte at the lowest address is the high byte of the first word, and memory returns that byte in `m_readdata[31:24]`, the next in 23:16, and so on. The result is not inverted.
- R3: When the byte count is not a multiple of four, the bytes past the count in the last fetched word are treated as zero. An odd count therefore makes the final byte the high byte of a word whose low byte is zero.
- R4: Starting with a byte count of zero sets done and clears the result to 0 at the next clock edge, leaves busy low, and issues no memory read.
- R5: The master reads consecutive 32-bit words upward from the start address with its two low bits forced to zero. While `m_read` is high and `m_waitrequest` is high, `m_read` stays high and `m_address` does not change.
- R6: At most two accepted reads are ever waiting for data, and data is taken only in cycles where `m_readdatavalid` is high.
- R7: With no stalls and one cycle of read latency, a 1300-byte job sets done within 340 cycles of the start command.
- R8: A start command written while busy is ignored. The running job completes with its original address and count.
- R9: Busy rises at the clock edge of an accepted start for a non-empty payload and falls when the result is written, at the same edge that done rises. An accepted start clears done. Busy and done are never high together, and the master requests nothing while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_addr | input | 4 | Register byte offset |
| s_write | input | 1 | Register write strobe |
| s_wdata | input | 32 | Register write data |
| s_rdata | output | 32 | Register read data, combinational from `s_addr` |
| m_address | output | AW (32) | Read master byte address, word aligned |
| m_read | output | 1 | Read request |
| m_waitrequest | input | 1 | Arbiter hold-off, request not taken while high |
| m_readdata | input | 32 | Returned memory word |
| m_readdatavalid | input | 1 | Marks `m_readdata` as valid |

## Verification
The bench drives a memory model with one cycle of latency. It can stall requests in a pseudo-random pattern, so a master that let its address drift during a hold-off, or that counted a request as taken before the arbiter released it, would fetch wrong or duplicate words and produce a wrong sum. Payload lengths of 1, 2, 3, 5 and 7 bytes sit next to memory that holds non-zero garbage, so a design that skipped masking would add stray bytes. An all-ones payload forces repeated end-around carries, which catches a fold that stops after one pass. A zero-length start, a restart attempt in the middle of a long job, and an unaligned start address are each checked against the sum computed in the bench and against the number of reads the master issues.

// File: rtl/csum_pkg.sv
package csum_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_SUM  = 2'd1,
        ACC_FOLD = 2'd2
    } acc_state_e;

    // keep mask for the last word; tail = byte count modulo four
    function automatic logic [31:0] tail_keep(input logic [1:0] tail);
        logic [31:0] m;
        case (tail)
            2'd1:    m = 32'hFF00_0000;
            2'd2:    m = 32'hFFFF_0000;
            2'd3:    m = 32'hFFFF_FF00;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/csum_regs.sv
module csum_regs #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    s_addr,
    input  logic          s_write,
    input  logic [31:0]   s_wdata,
    output logic [31:0]   s_rdata,
    input  logic          fin,
    input  logic [15:0]   fin_sum,
    output logic [AW-1:0] base_o,
    output logic [LW-1:0] len_o,
    output logic          go_o,
    output logic          busy_o,
    output logic          done_o
);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [LW-1:0] len;
        logic          busy;
        logic          done;
        logic [15:0]   result;
    } regs_t;

    regs_t q, d;
    logic  go_d;

    always_comb begin
        d    = q;
        go_d = 1'b0;
        if (fin) begin
            d.busy   = 1'b0;
            d.done   = 1'b1;
            d.result = fin_sum;
        end
        if (s_write) begin
            case (s_addr[3:2])
                2'd0: d.base = s_wdata[AW-1:0];
                2'd1: d.len  = s_wdata[LW-1:0];
                2'd2: begin
                    if (s_wdata[0] && !q.busy) begin
                        if (q.len == '0) begin
                            d.done   = 1'b1;
                            d.result = 16'h0000;
                        end else begin
                            d.busy = 1'b1;
                            d.done = 1'b0;
                            go_d   = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (s_addr[3:2])
            2'd0:    s_rdata = 32'(q.base);
            2'd1:    s_rdata = 32'(q.len);
            2'd2:    s_rdata = {30'd0, q.done, q.busy};
            default: s_rdata = {16'd0, q.result};
        endcase
    end

    assign base_o = q.base;
    assign len_o  = q.len;
    assign go_o   = go_d;
    assign busy_o = q.busy;
    assign done_o = q.done;

endmodule

// File: rtl/csum_fetch.sv
module csum_fetch #(
    parameter int AW      = 32,
    parameter int WW      = 15,
    parameter int MAX_OUT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] base,
    input  logic [WW-1:0] nwords,
    output logic [AW-1:0] m_address,
    output logic          m_read,
    input  logic          m_waitrequest,
    input  logic          m_readdatavalid
);

    localparam int OW = $clog2(MAX_OUT + 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [WW-1:0] left;
        logic [OW-1:0] outst;
        logic          rd;
    } fetch_t;

    fetch_t q, d;
    logic   taken;

    always_comb begin
        d     = q;
        taken = q.rd && !m_waitrequest;
        if (taken) begin
            d.addr = q.addr + AW'(4);
            d.left = q.left - WW'(1);
        end
        d.outst = q.outst + OW'(taken) - OW'(m_readdatavalid);
        if (go) begin
            d.addr = {base[AW-1:2], 2'b00};
            d.left = nwords;
        end
        d.rd = (d.left != '0) && (d.outst < OW'(MAX_OUT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign m_address = q.addr;
    assign m_read    = q.rd;

endmodule

// File: rtl/csum_accum.sv
module csum_accum
    import csum_pkg::*;
#(
    parameter int LW = 16,
    parameter int WW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [WW-1:0] nwords,
    input  logic [1:0]    tail,
    input  logic          rvalid,
    input  logic [31:0]   rdata,
    output logic          fin,
    output logic [15:0]   sum
);

    localparam int ACC_W = LW + 16;

    typedef struct packed {
        acc_state_e     st;
        logic [ACC_W-1:0] acc;
        logic [WW-1:0]  left;
        logic [1:0]     tail;
    } acc_t;

    acc_t        q, d;
    logic        fin_d;
    logic        last;
    logic [31:0] word;

    always_comb begin
        d     = q;
        fin_d = 1'b0;
        last  = (q.left == WW'(1));
        word  = last ? (rdata & tail_keep(q.tail)) : rdata;
        case (q.st)
            ACC_IDLE: begin
                if (go) begin
                    d.st   = ACC_SUM;
                    d.acc  = '0;
                    d.left = nwords;
                    d.tail = tail;
                end
            end
            ACC_SUM: begin
                if (rvalid) begin
                    d.acc  = q.acc + ACC_W'(word[31:16]) + ACC_W'(word[15:0]);
                    d.left = q.left - WW'(1);
                    if (last) begin
                        d.st = ACC_FOLD;
                    end
                end
            end
            ACC_FOLD: begin
                if (q.acc[ACC_W-1:16] != '0) begin
                    d.acc = ACC_W'(q.acc[15:0]) + (q.acc >> 16);
                end else begin
                    fin_d = 1'b1;
                    d.st  = ACC_IDLE;
                end
            end
            default: d.st = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fin = fin_d;
    assign sum = q.acc[15:0];

endmodule

// File: rtl/csum_engine.sv
module csum_engine #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    s_addr,
    input  logic          s_write,
    input  logic [31:0]   s_wdata,
    output logic [31:0]   s_rdata,
    output logic [AW-1:0] m_address,
    output logic          m_read,
    input  logic          m_waitrequest,
    input  logic [31:0]   m_readdata,
    input  logic          m_readdatavalid
);

    localparam int WW = LW - 1;

    logic [AW-1:0] base_w;
    logic [LW-1:0] len_w;
    logic          go_w;
    logic          busy_w;
    logic          done_w;
    logic          fin_w;
    logic [15:0]   sum_w;
    logic [LW:0]   len_up;
    logic [WW-1:0] nwords_w;

    assign len_up   = {1'b0, len_w} + (LW + 1)'(3);
    assign nwords_w = len_up[LW:2];

    csum_regs #(.AW(AW), .LW(LW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_addr  (s_addr),
        .s_write (s_write),
        .s_wdata (s_wdata),
        .s_rdata (s_rdata),
        .fin     (fin_w),
        .fin_sum (sum_w),
        .base_o  (base_w),
        .len_o   (len_w),
        .go_o    (go_w),
        .busy_o  (busy_w),
        .done_o  (done_w)
    );

    csum_fetch #(.AW(AW), .WW(WW), .MAX_OUT(2)) u_fetch (
        .clk             (clk),
        .rst_n           (rst_n),
        .go              (go_w),
        .base            (base_w),
        .nwords          (nwords_w),
        .m_address       (m_address),
        .m_read          (m_read),
        .m_waitrequest   (m_waitrequest),
        .m_readdatavalid (m_readdatavalid)
    );

    csum_accum #(.LW(LW), .WW(WW)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go_w),
        .nwords (nwords_w),
        .tail   (len_w[1:0]),
        .rvalid (m_readdatavalid),
        .rdata  (m_readdata),
        .fin    (fin_w),
        .sum    (sum_w)
    );

endmodule

// File: rtl/csum_engine_chk.sv
module csum_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          m_read,
    input logic          m_waitrequest,
    input logic [AW-1:0] m_address,
    input logic          m_readdatavalid,
    input logic          busy,
    input logic          done
);

    logic [2:0] inflight;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight <= '0;
        end else begin
            inflight <= inflight + 3'(m_read && !m_waitrequest) - 3'(m_readdatavalid);
        end
    end

    // R5: request and address held through a hold-off
    a_r5_hold_under_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (m_read && m_waitrequest) |=> (m_read && $stable(m_address)));

    // R5: word-aligned addresses only
    a_r5_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        m_read |-> (m_address[1:0] == 2'b00));

    // R6: never more than two reads waiting for data
    a_r6_max_two_inflight: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= 3'd2);

    // R6: no data without a pending read
    a_r6_no_orphan_data: assert property (@(posedge clk) disable iff (!rst_n)
        m_readdatavalid |-> (inflight != 3'd0));

    // R9: busy and done exclusive
    a_r9_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R9: no request while idle
    a_r9_no_read_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !m_read);

    // R9: done rises exactly as busy falls
    a_r9_done_with_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

bind csum_engine csum_engine_chk #(.AW(AW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .m_read          (m_read),
    .m_waitrequest   (m_waitrequest),
    .m_address       (m_address),
    .m_readdatavalid (m_readdatavalid),
    .busy            (busy_w),
    .done            (done_w)
);

// File: tb/sim_csum_engine.sv
`timescale 1ns/1ps
module sim_csum_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  s_addr = 4'd0;
    logic        s_write = 1'b0;
    logic [31:0] s_wdata = 32'd0;
    logic [31:0] s_rdata;
    logic [31:0] m_address;
    logic        m_read;
    logic        m_waitrequest = 1'b0;
    logic [31:0] m_readdata = 32'd0;
    logic        m_readdatavalid = 1'b0;

    always #10 clk = ~clk;

    csum_engine u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .s_addr          (s_addr),
        .s_write         (s_write),
        .s_wdata         (s_wdata),
        .s_rdata         (s_rdata),
        .m_address       (m_address),
        .m_read          (m_read),
        .m_waitrequest   (m_waitrequest),
        .m_readdata      (m_readdata),
        .m_readdatavalid (m_readdatavalid)
    );

    int compared = 0;
    int mismatched = 0;
    int mon_err = 0;

    logic [31:0] mem [0:1023];

    // memory / arbiter model, all driven on the falling edge
    logic        stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = 32'd0;
    logic        prv_rd = 1'b0;
    logic        prv_wait = 1'b0;
    logic [31:0] prv_addr = 32'd0;
    logic [31:0] exp_addr = 32'd0;
    int          issued = 0;
    int          returned = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            pend = 1'b0;
            m_readdatavalid = 1'b0;
            m_waitrequest = 1'b0;
            prv_rd = 1'b0;
        end else begin
            if (prv_rd && prv_wait && (!m_read || m_address !== prv_addr)) begin
                mon_err++;
                mismatched++;
                $display("FAIL R5: request moved under hold-off, actual rd=%0b addr=%h expected rd=1 addr=%h",
                         m_read, m_address, prv_addr);
            end
            if (m_readdatavalid) returned++;
            m_readdatavalid = pend;
            m_readdata = pend ? mem[pend_addr[11:2]] : 32'hDEAD_BEEF;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            m_waitrequest = stall_en && lfsr[0];
            pend = m_read && !m_waitrequest;
            if (pend) begin
                pend_addr = m_address;
                if (m_address !== exp_addr) begin
                    mon_err++;
                    mismatched++;
                    $display("FAIL R5: read address actual %h expected %h", m_address, exp_addr);
                end
                if (issued - returned >= 2) begin
                    mon_err++;
                    mismatched++;
                    $display("FAIL R6: inflight actual %0d expected <2 before accept", issued - returned);
                end
                exp_addr = exp_addr + 32'd4;
                issued++;
            end
            prv_rd = m_read;
            prv_wait = m_waitrequest;
            prv_addr = m_address;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        s_addr = a;
        s_wdata = v;
        s_write = 1'b1;
        @(negedge clk);
        s_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        s_addr = a;
        #1;
        v = s_rdata;
    endtask

    function automatic logic [7:0] mbyte(input int a);
        logic [31:0] w;
        w = mem[(a >> 2) & 1023];
        return 8'(w >> (24 - 8 * (a & 3)));
    endfunction

    function automatic logic [15:0] ref_sum(input int b, input int len);
        int s;
        int a0;
        a0 = b & ~3;
        s = 0;
        for (int i = 0; i < len; i += 2) begin
            s += {mbyte(a0 + i), (i + 1 < len) ? mbyte(a0 + i + 1) : 8'h00};
        end
        while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
        return 16'(s);
    endfunction

    // starts a job; returns cycles until done seen
    task automatic run_job(input int b, input int len, output int cycles);
        logic [31:0] st;
        wr(4'h0, 32'(b));
        wr(4'h4, 32'(len));
        exp_addr = 32'(b) & ~32'd3;
        wr(4'h8, 32'd1);
        cycles = 1;
        rd(4'h8, st);
        while (st[1] !== 1'b1 && cycles < 5000) begin
            @(negedge clk);
            cycles++;
            rd(4'h8, st);
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(4'h0, v); chk("R1 reset base", v, 0);
        rd(4'h4, v); chk("R1 reset len", v, 0);
        rd(4'h8, v); chk("R1 reset status", v, 0);
        rd(4'hC, v); chk("R1 reset result", v, 0);
    endtask

    task automatic t_zero_len;
        logic [31:0] v;
        int n0;
        wr(4'h4, 32'd0);
        n0 = issued;
        wr(4'h8, 32'd1);
        rd(4'h8, v); chk("R4 zero length status", v, 32'd2);
        rd(4'hC, v); chk("R4 zero length result", v, 0);
        repeat (4) @(negedge clk);
        chk("R4 zero length no reads", 32'(issued - n0), 0);
    endtask

    task automatic t_basic;
        logic [31:0] v;
        int c;
        int n0;
        n0 = issued;
        run_job(32'h100, 8, c);
        rd(4'h0, v); chk("R1 base readback", v, 32'h100);
        rd(4'h4, v); chk("R1 len readback", v, 8);
        rd(4'hC, v); chk("R2 8-byte sum", v, 32'(ref_sum(32'h100, 8)));
        rd(4'h8, v); chk("R9 status after job", v, 32'd2);
        chk("R5 reads for 8 bytes", 32'(issued - n0), 2);
    endtask

    task automatic t_long;
        logic [31:0] v;
        int c;
        run_job(0, 1300, c);
        rd(4'hC, v); chk("R2 1300-byte sum", v, 32'(ref_sum(0, 1300)));
        chk("R7 1300 bytes within 340 cycles", 32'(c <= 340), 1);
    endtask

    task automatic t_odd;
        logic [31:0] v;
        int c;
        int lens [5] = '{1, 2, 3, 5, 7};
        foreach (lens[k]) begin
            run_job(32'h300, lens[k], c);
            rd(4'hC, v);
            chk($sformatf("R3 tail mask len %0d", lens[k]), v, 32'(ref_sum(32'h300, lens[k])));
        end
    endtask

    task automatic t_stall;
        logic [31:0] v;
        int c;
        int n0;
        int e0;
        n0 = issued;
        e0 = mon_err;
        stall_en = 1'b1;
        run_job(32'h400, 600, c);
        stall_en = 1'b0;
        rd(4'hC, v); chk("R6 sum under stalls", v, 32'(ref_sum(32'h400, 600)));
        chk("R5 reads under stalls", 32'(issued - n0), 150);
        chk("R5/R6 monitor clean under stalls", 32'(mon_err - e0), 0);
    endtask

    task automatic t_restart_busy;
        logic [31:0] v;
        int n0;
        int cyc;
        n0 = issued;
        wr(4'h0, 32'd0);
        wr(4'h4, 32'd1300);
        exp_addr = 32'd0;
        wr(4'h8, 32'd1);
        rd(4'h8, v); chk("R9 busy after start", v, 32'd1);
        wr(4'h0, 32'h800);
        wr(4'h8, 32'd1);
        rd(4'h8, v); chk("R8 still busy after ignored start", v, 32'd1);
        cyc = 0;
        rd(4'h8, v);
        while (v[1] !== 1'b1 && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            rd(4'h8, v);
        end
        rd(4'hC, v); chk("R8 result of original job", v, 32'(ref_sum(0, 1300)));
        chk("R8 read count of original job", 32'(issued - n0), 325);
    endtask

    task automatic t_done_clear;
        logic [31:0] v;
        wr(4'h0, 32'h200);
        wr(4'h4, 32'd64);
        exp_addr = 32'h200;
        wr(4'h8, 32'd1);
        rd(4'h8, v); chk("R9 done cleared by start", v, 32'd1);
        repeat (40) @(negedge clk);
        rd(4'h8, v); chk("R9 done after job", v, 32'd2);
    endtask

    task automatic t_all_ones;
        logic [31:0] v;
        int c;
        for (int i = 0; i < 16; i++) mem[(32'h600 >> 2) + i] = 32'hFFFF_FFFF;
        run_job(32'h600, 64, c);
        rd(4'hC, v); chk("R2 all-ones fold", v, 32'h0000_FFFF);
    endtask

    task automatic t_unaligned;
        logic [31:0] v;
        int c;
        run_job(32'h503, 12, c);
        rd(4'hC, v); chk("R5 unaligned base uses word start", v, 32'(ref_sum(32'h500, 12)));
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = (32'(i) * 32'h9E37_79B9) ^ (32'(i) << 7) ^ 32'h5A5A_0F0F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_len();
        t_basic();
        t_long();
        t_odd();
        t_stall();
        t_restart_busy();
        t_done_clear();
        t_all_ones();
        t_unaligned();
        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule